// File: doc/BRIEF.md
# Delayed Single-Pulse Channel Generator

This block is one output lane of a digital pattern generator running from a fast system clock. A programmable prescaler turns the system clock into a slower tick. A state machine then spends a programmable number of ticks in a hold phase, where the pin stays at its idle level. After that it drives the pin high for a programmable number of ticks and then low for another. In single-shot mode it produces exactly one pulse and goes back to idle. In free-running mode it repeats the high/low cycle without end, until reset.

A start strobe accepted while the lane is idle captures the whole configuration: divider, hold count, high count, low count, idle level and mode. The busy flag stays up until the lane is idle again. A start strobe, or any change to the configuration, while the lane is busy has no effect.

The state machine has four states. `ST_IDLE` waits for a start. `ST_HOLD` counts the initial delay. `ST_HIGH` drives the pin high. `ST_LOW` drives the pin low. The transitions are:
- start with a zero hold count goes `ST_IDLE`→`ST_HIGH`;
- start with a nonzero hold count goes `ST_IDLE`→`ST_HOLD`;
- the last hold tick goes `ST_HOLD`→`ST_HIGH`;
- the last high tick goes `ST_HIGH`→`ST_LOW`;
- the last low tick goes `ST_LOW`→`ST_IDLE` in single-shot mode;
- the last low tick goes `ST_LOW`→`ST_HIGH` in free-running mode.

Top module: `pulse_channel_gen`

## Requirements
In the requirements below, edge n is the n-th rising clock edge after the edge that samples an accepted start (edge 0). Div, D, H and L are the captured divider, hold, high and low values.
- R1: State changes after edge 0 happen only at edges that are a whole multiple of Div. A divider value of 0 acts as 1.
- R2: Each high phase lasts H·Div clock cycles and each low phase lasts L·Div clock cycles.
- R3: A high or low count of 0 behaves exactly like a count of 1.
- R4: With D>0, wave_o keeps the captured idle level from edge 0 until edge D·Div, and rises at that edge. With D=0, wave_o is high from edge 0.
- R5: While busy_o is 0, wave_o equals cfg_idle_i. After reset, busy_o is 0.
- R6: With cfg_oneshot_i=1 captured, the lane emits exactly one high phase and one low phase. It then returns to idle at edge (D+H+L)·Div and stays there.
- R7: With cfg_oneshot_i=0 captured, the high/low cycle repeats with period (H+L)·Div, and busy_o does not fall.
- R8: A start strobe, and any change of the configuration inputs, while busy_o is 1 has no effect on the running waveform or its end time.
- R9: busy_o is 1 from edge 0 until the edge at which the lane re-enters idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| cfg_div_i | input | DIV_W | Prescaler divider (0 acts as 1) |
| cfg_delay_i | input | CNT_W | Hold ticks before the first rising edge |
| cfg_high_i | input | CNT_W | High phase length in ticks (0 acts as 1) |
| cfg_low_i | input | CNT_W | Low phase length in ticks (0 acts as 1) |
| cfg_idle_i | input | 1 | Idle level of the pin |
| cfg_oneshot_i | input | 1 | 1: single pulse, 0: free-running |
| busy_o | output | 1 | Lane is running |
| wave_o | output | 1 | Channel output pin |

## Verification
A wrong prescaler phase shows up as an edge of wave_o that falls off a multiple of Div. This is visible on the first edge after the hold phase, at most D·Div cycles after start. A miscounted hold, high or low counter shifts every later edge, and the very next expected transition exposes it at the ports. A bad return path in single-shot mode shows as a second rising edge, or as busy_o staying high, within one further (H+L)·Div window. The bench sweeps every small combination of divider, counts, idle level and mode, and compares the pins in every cycle against an arithmetic model.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } pcg_state_e;
endpackage

// File: rtl/pcg_prescaler.sv
module pcg_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;

    assign tick_o = run_i && (phase_q == div_i - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= tick_o ? '0 : phase_q + DIV_W'(1);
        end
    end

    // R1: the phase counter never passes the divider while running
    assert_phase_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (phase_q < div_i));
endmodule

// File: rtl/pcg_phase_fsm.sv
module pcg_phase_fsm
    import pcg_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic [CNT_W-1:0] cfg_delay_i,
    input  logic [CNT_W-1:0] cfg_high_i,
    input  logic [CNT_W-1:0] cfg_low_i,
    input  logic             cfg_idle_i,
    input  logic             cfg_oneshot_i,
    input  logic             tick_i,
    output logic             accept_o,
    output logic             run_o,
    output logic [DIV_W-1:0] div_o,
    output logic             busy_o,
    output logic             wave_o
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [DIV_W-1:0] ONE_D = DIV_W'(1);

    pcg_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] hi_q, lo_q;
    logic [DIV_W-1:0] div_q;
    logic             idle_q, os_q;
    logic [CNT_W-1:0] hi_fix, lo_fix;

    assign hi_fix = (cfg_high_i == '0) ? ONE_C : cfg_high_i;
    assign lo_fix = (cfg_low_i  == '0) ? ONE_C : cfg_low_i;

    // next-state decode
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        accept_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    if (cfg_delay_i == '0) begin
                        st_d  = ST_HIGH;
                        cnt_d = hi_fix;
                    end else begin
                        st_d  = ST_HOLD;
                        cnt_d = cfg_delay_i;
                    end
                end
            end
            ST_HOLD: begin
                if (tick_i) begin
                    if (cnt_q == ONE_C) begin
                        st_d  = ST_HIGH;
                        cnt_d = hi_q;
                    end else begin
                        cnt_d = cnt_q - ONE_C;
                    end
                end
            end
            ST_HIGH: begin
                if (tick_i) begin
                    if (cnt_q == ONE_C) begin
                        st_d  = ST_LOW;
                        cnt_d = lo_q;
                    end else begin
                        cnt_d = cnt_q - ONE_C;
                    end
                end
            end
            ST_LOW: begin
                if (tick_i) begin
                    if (cnt_q == ONE_C) begin
                        st_d  = os_q ? ST_IDLE : ST_HIGH;
                        cnt_d = os_q ? '0 : hi_q;
                    end else begin
                        cnt_d = cnt_q - ONE_C;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            hi_q   <= ONE_C;
            lo_q   <= ONE_C;
            div_q  <= ONE_D;
            idle_q <= 1'b0;
            os_q   <= 1'b1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (accept_o) begin
                hi_q   <= hi_fix;
                lo_q   <= lo_fix;
                div_q  <= (cfg_div_i == '0) ? ONE_D : cfg_div_i;
                idle_q <= cfg_idle_i;
                os_q   <= cfg_oneshot_i;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_IDLE: wave_o = cfg_idle_i;
            ST_HOLD: wave_o = idle_q;
            ST_HIGH: wave_o = 1'b1;
            ST_LOW:  wave_o = 1'b0;
        endcase
        busy_o = (st_q != ST_IDLE);
        run_o  = busy_o;
        div_o  = div_q;
    end

    // R1: between ticks a running lane keeps its state
    assert_move_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !tick_i) |=> (st_q == $past(st_q)));
    // R3: an active phase never holds a zero count
    assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH || st_q == ST_LOW) |-> (cnt_q != '0));
    // R2: the low phase is entered only from the high phase
    assert_low_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW && $past(st_q) != ST_LOW) |-> ($past(st_q) == ST_HIGH));
    // R8: captured settings hold while busy
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(hi_q) && $stable(lo_q) && $stable(div_q) && $stable(os_q)));
    // R7: a free-running lane never drops busy
    assert_freerun_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !os_q) |=> busy_o);
endmodule

// File: rtl/pulse_channel_gen.sv
module pulse_channel_gen #(
    parameter int DIV_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic [CNT_W-1:0] cfg_delay_i,
    input  logic [CNT_W-1:0] cfg_high_i,
    input  logic [CNT_W-1:0] cfg_low_i,
    input  logic             cfg_idle_i,
    input  logic             cfg_oneshot_i,
    output logic             busy_o,
    output logic             wave_o
);
    logic             tick;
    logic             accept;
    logic             run;
    logic [DIV_W-1:0] div_cur;

    pcg_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .run_i   (run),
        .div_i   (div_cur),
        .tick_o  (tick)
    );

    pcg_phase_fsm #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cfg_div_i     (cfg_div_i),
        .cfg_delay_i   (cfg_delay_i),
        .cfg_high_i    (cfg_high_i),
        .cfg_low_i     (cfg_low_i),
        .cfg_idle_i    (cfg_idle_i),
        .cfg_oneshot_i (cfg_oneshot_i),
        .tick_i        (tick),
        .accept_o      (accept),
        .run_o         (run),
        .div_o         (div_cur),
        .busy_o        (busy_o),
        .wave_o        (wave_o)
    );

    // R9: an accepted start raises busy at the next edge
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/tb_pulse_channel_gen.sv
module tb_pulse_channel_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] cfg_div_i = '0;
    logic [CW-1:0] cfg_delay_i = '0;
    logic [CW-1:0] cfg_high_i = '0;
    logic [CW-1:0] cfg_low_i = '0;
    logic          cfg_idle_i = 1'b0;
    logic          cfg_oneshot_i = 1'b1;
    logic          busy_o;
    logic          wave_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_channel_gen #(.DIV_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_div_i(cfg_div_i), .cfg_delay_i(cfg_delay_i),
        .cfg_high_i(cfg_high_i), .cfg_low_i(cfg_low_i),
        .cfg_idle_i(cfg_idle_i), .cfg_oneshot_i(cfg_oneshot_i),
        .busy_o(busy_o), .wave_o(wave_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one run: reset, start, compare every cycle against the arithmetic model
    task automatic run_case(input int dv, input int d, input int h, input int l,
                            input bit idl, input bit os, input bit perturb, input int span);
        int dve = (dv == 0) ? 1 : dv;
        int he  = (h == 0) ? 1 : h;
        int le  = (l == 0) ? 1 : l;
        int t0  = d * dve;
        int hp  = he * dve;
        int lp  = le * dve;
        int fin = t0 + hp + lp;
        bit live_idle = idl;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_div_i = DW'(dv); cfg_delay_i = CW'(d);
        cfg_high_i = CW'(h); cfg_low_i = CW'(l);
        cfg_idle_i = idl; cfg_oneshot_i = os;
        @(negedge clk);
        chk(busy_o == 1'b0, "R5 reset busy", int'(busy_o), 0);
        chk(wave_o == idl, "R5 reset idle level", int'(wave_o), int'(idl));
        rst_n = 1'b1;
        @(negedge clk);
        start_i = 1'b1;
        for (int n = 0; n <= span; n++) begin
            bit ew, eb;
            int r;
            @(negedge clk);
            start_i = 1'b0;
            if (n < t0) begin
                ew = idl; eb = 1'b1;
            end else begin
                r = n - t0;
                if (os && r >= hp + lp) begin
                    ew = live_idle; eb = 1'b0;
                end else begin
                    r = r % (hp + lp);
                    ew = (r < hp); eb = 1'b1;
                end
            end
            if (n < t0)
                chk(wave_o == ew, "R4 hold phase", int'(wave_o), int'(ew));
            else if (eb)
                chk(wave_o == ew, os ? "R2 R3 R1 pulse shape" : "R7 free-run shape",
                    int'(wave_o), int'(ew));
            else
                chk(wave_o == ew, "R6 R5 back to idle", int'(wave_o), int'(ew));
            chk(busy_o == eb, os ? "R9 R6 busy" : "R7 R9 busy", int'(busy_o), int'(eb));
            if (perturb && n == 1 && fin > 3) begin
                // R8: change every setting and retry start while busy
                start_i = 1'b1;
                cfg_div_i = DW'(dv + 3); cfg_delay_i = CW'(d + 2);
                cfg_high_i = CW'(h + 4); cfg_low_i = CW'(l + 1);
                cfg_oneshot_i = ~os;
                if (n + 1 >= t0) begin
                    cfg_idle_i = ~idl;
                    live_idle = ~idl;
                end
            end
        end
        start_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // near-exhaustive single-shot sweep (R1 R2 R3 R4 R5 R6 R8 R9)
        for (int dv = 0; dv <= 3; dv++)
            for (int d = 0; d <= 2; d++)
                for (int h = 0; h <= 2; h++)
                    for (int l = 0; l <= 2; l++)
                        for (int idl = 0; idl <= 1; idl++) begin
                            int dve = (dv == 0) ? 1 : dv;
                            int sp = (d + ((h == 0) ? 1 : h) + ((l == 0) ? 1 : l)) * dve + 3;
                            run_case(dv, d, h, l, idl[0], 1'b1, dv == 2, sp);
                        end
        // free-running cycles (R7 R3)
        for (int dv = 1; dv <= 3; dv++)
            for (int idl = 0; idl <= 1; idl++)
                run_case(dv, 1, dv, 3 - dv, idl[0], 1'b0, 1'b1, (1 + 3 * 3) * dv + 2);
        // minimum counts halve the tick rate: div 10, high 1, low 1 -> period 20 (R7)
        run_case(10, 0, 1, 1, 1'b0, 1'b0, 1'b0, 70);
        // long hold: 300 ticks of 5 cycles before the first rise, 2/2 pulse (R4 R6)
        run_case(5, 300, 2, 2, 1'b0, 1'b1, 1'b0, 1530);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule